// File: doc/BRIEF.md
# Packet-Device Task-File Register Block

This block is the device-side register file of an ATA packet device on an 8-bit host register bus. It holds these registers:

- feature
- sector count
- three address bytes
- device select
- command/status
- error
- an interrupt-enable bit taken from the device-control register

It filters host writes against the device's busy and data-request status bits. It turns command-register writes into status updates through a two-state sequencer, with states `TF_IDLE` and `TF_DECODE`. It also keeps an interrupt-pending flag that is separate from the interrupt line it reports.

A system event controller watches two one-cycle pulses, `irq_raise` and `irq_clear`. It counts on exactly one pulse for each change of the visible interrupt line. A separate data-phase engine does two things. It overwrites status, for example to set or drop BUSY or DRQ, through `eng_status_we`. It reports an error through `eng_fault`. It takes `pkt_start` as the signal that a packet command has been accepted.

Sequencer transitions:

- **T1 (`TF_IDLE` to `TF_DECODE`):** an accepted command write.
- **T2 (`TF_DECODE` to `TF_IDLE`):** always, one cycle later.
- **Otherwise:** stay in `TF_IDLE`.

While in `TF_DECODE` the latched command is classified:

- `08h` is device reset.
- `A0h` is packet.
- `EFh` is set-feature.
- Any other value is a generic command.

Top module: `pktdev_taskfile`

## Requirements
- R1: After reset the registers read back as follows, and the interrupt-enable bit is 0, meaning enabled:
  - error = 01h
  - count = 01h
  - address low/mid/high = 81h/14h/EBh
  - device, feature and status = 00h
  - interrupt pending clear
- R2: Host writes to feature (address 1), count (2), address low/mid/high (3/4/5), device (6) and command (7) are dropped in two cases:
  - status AND 88h is nonzero, that is BUSY (bit 7) or DRQ (bit 3) is set;
  - the sequencer is in `TF_DECODE`.
- R3: `rdata` holds the addressed register in the cycle after a read strobe and is 00h otherwise:
  - address 1 reads error;
  - addresses 2 to 6 read back their registers;
  - address 7 reads status;
  - address 8 reads status as alternate status;
  - any other address reads 00h.
- R4: A read at address 8 (alternate status) never changes the pending flag.
- R5: A read at address 7 clears pending only when BUSY (bit 7) is 0. If pending was set and interrupts are enabled, that read emits an `irq_clear` pulse.
- R6: An accepted command write clears pending first. Two clock edges after the strobe, status has READY (bit 6) and SERVICE (bit 4) set; any other command code gives status OR 50h.
- R7: Set-feature (`EFh`) sets pending on completion. An `irq_raise` pulse appears at the same edge as the status update if interrupts are enabled.
- R8: Packet (`A0h`) sets DRQ, READY and SERVICE (status OR 58h) and pulses `pkt_start` for one cycle at the same edge.
- R9: Device reset (`08h`) restores feature, count, address, device and error to their R1 values and leaves status at 50h.
- R10: The host writes the interrupt-disable bit as bit 1 of address 8. While pending is set:
  - writing bit 1 from 0 to 1 emits `irq_clear`;
  - writing bit 1 from 1 to 0 emits `irq_raise`.
  - With pending clear, a write to address 8 emits no pulse.
- R11: A raise when pending is already set emits nothing. A raise or clear while interrupts are disabled changes pending but emits no pulse.
- R12: `eng_fault` loads status with 51h and error with `eng_fault_code` at the next edge. It takes priority over `eng_status_we` and over command completion.
- R13: `intrq` is high exactly when pending is set and the interrupt-disable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (4) | Register address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | DW (8) | Host write data |
| rdata | output | DW (8) | Registered read data |
| eng_status_we | input | 1 | Data engine loads status |
| eng_status | input | DW (8) | Status value from data engine |
| eng_fault | input | 1 | Data engine reports an error |
| eng_fault_code | input | DW (8) | Error code loaded into the error register |
| irq_raise | output | 1 | One-cycle raise-event pulse |
| irq_clear | output | 1 | One-cycle clear-event pulse |
| intrq | output | 1 | Interrupt line level |
| pkt_start | output | 1 | One-cycle pulse when a packet command completes decode |

## Verification
Results fall due at fixed delays after a strobe:

- **One edge after the strobe:**
  - register writes, visible on a following read;
  - read data;
  - pulses from status reads, control writes and command-write clears;
  - engine status and fault loads.
- **Two edges after the command strobe, through `TF_DECODE`:**
  - the status update from a command;
  - the raise from set-feature;
  - the `pkt_start` pulse.

The bench drives inputs just after each falling edge. Its behavioural model advances at the rising edge from the same inputs. Every output is compared at the next falling edge, so each comparison falls on the cycle where the registered result is due. Directed reads and interrupt-line checks with fixed expected values sit on top of the model.

// File: rtl/pktdev_tf_pkg.sv
package pktdev_tf_pkg;

    localparam int TF_DW = 8;
    localparam int TF_AW = 4;

    // register addresses
    localparam int A_FEAT_ERR = 1;
    localparam int A_COUNT    = 2;
    localparam int A_ADR_LO   = 3;
    localparam int A_ADR_MID  = 4;
    localparam int A_ADR_HI   = 5;
    localparam int A_DEVSEL   = 6;
    localparam int A_CMD_STAT = 7;
    localparam int A_CTL_ALT  = 8;

    // status masks and values
    localparam int ST_BUSY  = 'h80;
    localparam int ST_READY = 'h40;
    localparam int ST_SERV  = 'h10;
    localparam int ST_DRQ   = 'h08;
    localparam int ST_BLOCK = 'h88;
    localparam int ST_FAULT = 'h51;

    // command codes
    localparam int CMD_DEV_RESET = 'h08;
    localparam int CMD_PACKET    = 'hA0;
    localparam int CMD_SET_FEAT  = 'hEF;

    // reset values
    localparam int RV_ERROR   = 'h01;
    localparam int RV_COUNT   = 'h01;
    localparam int RV_ADR_LO  = 'h81;
    localparam int RV_ADR_MID = 'h14;
    localparam int RV_ADR_HI  = 'hEB;

    localparam int NIEN_BIT = 1;

    typedef enum logic {
        TF_IDLE,
        TF_DECODE
    } tf_state_e;

    typedef enum logic [2:0] {
        DEC_NONE,
        DEC_RESET,
        DEC_PACKET,
        DEC_FEATURE,
        DEC_OTHER
    } tf_dec_e;

endpackage

// File: rtl/pktdev_tf_cmd_fsm.sv
module pktdev_tf_cmd_fsm
    import pktdev_tf_pkg::*;
#(
    parameter int DW = TF_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_accept,
    input  logic [DW-1:0] cmd_byte,
    output tf_state_e     state_o,
    output tf_dec_e       dec_o
);
    localparam logic [DW-1:0] K_RESET  = DW'(CMD_DEV_RESET);
    localparam logic [DW-1:0] K_PACKET = DW'(CMD_PACKET);
    localparam logic [DW-1:0] K_FEAT   = DW'(CMD_SET_FEAT);

    tf_state_e     state_q, state_d;
    logic [DW-1:0] cmd_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TF_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_accept && state_q == TF_IDLE)
                cmd_q <= cmd_byte;
        end
    end

    // transitions T1 / T2
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TF_IDLE:   if (cmd_accept) state_d = TF_DECODE;
            TF_DECODE: state_d = TF_IDLE;
            default:   state_d = TF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dec_o = DEC_NONE;
        unique case (state_q)
            TF_IDLE: dec_o = DEC_NONE;
            TF_DECODE: begin
                if (cmd_q == K_RESET)       dec_o = DEC_RESET;
                else if (cmd_q == K_PACKET) dec_o = DEC_PACKET;
                else if (cmd_q == K_FEAT)   dec_o = DEC_FEATURE;
                else                        dec_o = DEC_OTHER;
            end
            default: dec_o = DEC_NONE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pktdev_tf_irq.sv
module pktdev_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic nien_q,     // current interrupt-disable bit
    input  logic ctl_we,     // control register write
    input  logic nien_wr,    // bit being written
    input  logic clr_req,
    input  logic set_req,
    output logic pending_o,
    output logic raise_o,
    output logic clear_o
);
    logic pend_q, raise_q, clear_q;
    logic pend_d, raise_d, clear_d;

    // clear, then raise, then enable change, in that order
    always_comb begin
        pend_d  = pend_q;
        raise_d = 1'b0;
        clear_d = 1'b0;
        if (clr_req && pend_d) begin
            pend_d  = 1'b0;
            clear_d = !nien_q;
        end
        if (set_req && !pend_d) begin
            pend_d  = 1'b1;
            raise_d = !nien_q;
        end
        if (ctl_we && pend_d) begin
            if (!nien_q && nien_wr)  clear_d = 1'b1;
            if (nien_q  && !nien_wr) raise_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            raise_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            raise_q <= raise_d;
            clear_q <= clear_d;
        end
    end

    assign pending_o = pend_q;
    assign raise_o   = raise_q;
    assign clear_o   = clear_q;

endmodule

// File: rtl/pktdev_taskfile.sv
module pktdev_taskfile
    import pktdev_tf_pkg::*;
#(
    parameter int DW = TF_DW,
    parameter int AW = TF_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          eng_status_we,
    input  logic [DW-1:0] eng_status,
    input  logic          eng_fault,
    input  logic [DW-1:0] eng_fault_code,
    output logic          irq_raise,
    output logic          irq_clear,
    output logic          intrq,
    output logic          pkt_start
);
    localparam logic [AW-1:0] KA_ERR  = AW'(A_FEAT_ERR);
    localparam logic [AW-1:0] KA_CNT  = AW'(A_COUNT);
    localparam logic [AW-1:0] KA_LO   = AW'(A_ADR_LO);
    localparam logic [AW-1:0] KA_MID  = AW'(A_ADR_MID);
    localparam logic [AW-1:0] KA_HI   = AW'(A_ADR_HI);
    localparam logic [AW-1:0] KA_DEV  = AW'(A_DEVSEL);
    localparam logic [AW-1:0] KA_CMD  = AW'(A_CMD_STAT);
    localparam logic [AW-1:0] KA_CTL  = AW'(A_CTL_ALT);
    localparam logic [DW-1:0] K_BUSY  = DW'(ST_BUSY);
    localparam logic [DW-1:0] K_DONE  = DW'(ST_READY | ST_SERV);
    localparam logic [DW-1:0] K_DRQ   = DW'(ST_DRQ);
    localparam logic [DW-1:0] K_BLOCK = DW'(ST_BLOCK);
    localparam logic [DW-1:0] K_FAULT = DW'(ST_FAULT);

    logic [DW-1:0] feat_q, count_q, lo_q, mid_q, hi_q, dev_q;
    logic [DW-1:0] status_q, error_q, rdata_q, rd_mux;
    logic          nien_q, pkt_q;

    tf_state_e state_w;
    tf_dec_e   dec_w;
    logic      fsm_idle, host_ok, cmd_accept, stat_rd, clr_req, set_req, ctl_we, pend_w;

    assign fsm_idle   = (state_w == TF_IDLE);
    assign host_ok    = ((status_q & K_BLOCK) == '0) && fsm_idle;
    assign cmd_accept = wr_en && (addr == KA_CMD) && host_ok;
    assign stat_rd    = rd_en && (addr == KA_CMD);
    assign clr_req    = cmd_accept || (stat_rd && ((status_q & K_BUSY) == '0));
    assign set_req    = (dec_w == DEC_FEATURE);
    assign ctl_we     = wr_en && (addr == KA_CTL);

    pktdev_tf_cmd_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_accept (cmd_accept),
        .cmd_byte   (wdata),
        .state_o    (state_w),
        .dec_o      (dec_w)
    );

    pktdev_tf_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .nien_q    (nien_q),
        .ctl_we    (ctl_we),
        .nien_wr   (wdata[NIEN_BIT]),
        .clr_req   (clr_req),
        .set_req   (set_req),
        .pending_o (pend_w),
        .raise_o   (irq_raise),
        .clear_o   (irq_clear)
    );

    always_comb begin
        rd_mux = '0;
        case (addr)
            KA_ERR:  rd_mux = error_q;
            KA_CNT:  rd_mux = count_q;
            KA_LO:   rd_mux = lo_q;
            KA_MID:  rd_mux = mid_q;
            KA_HI:   rd_mux = hi_q;
            KA_DEV:  rd_mux = dev_q;
            KA_CMD:  rd_mux = status_q;
            KA_CTL:  rd_mux = status_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_q   <= '0;
            count_q  <= DW'(RV_COUNT);
            lo_q     <= DW'(RV_ADR_LO);
            mid_q    <= DW'(RV_ADR_MID);
            hi_q     <= DW'(RV_ADR_HI);
            dev_q    <= '0;
            status_q <= '0;
            error_q  <= DW'(RV_ERROR);
            nien_q   <= 1'b0;
            pkt_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (wr_en && host_ok) begin
                case (addr)
                    KA_ERR:  feat_q  <= wdata;
                    KA_CNT:  count_q <= wdata;
                    KA_LO:   lo_q    <= wdata;
                    KA_MID:  mid_q   <= wdata;
                    KA_HI:   hi_q    <= wdata;
                    KA_DEV:  dev_q   <= wdata;
                    default: ;
                endcase
            end
            unique case (dec_w)
                DEC_RESET: begin
                    feat_q   <= '0;
                    count_q  <= DW'(RV_COUNT);
                    lo_q     <= DW'(RV_ADR_LO);
                    mid_q    <= DW'(RV_ADR_MID);
                    hi_q     <= DW'(RV_ADR_HI);
                    dev_q    <= '0;
                    error_q  <= DW'(RV_ERROR);
                    status_q <= K_DONE;
                end
                DEC_PACKET:  status_q <= status_q | K_DRQ | K_DONE;
                DEC_FEATURE: status_q <= status_q | K_DONE;
                DEC_OTHER:   status_q <= status_q | K_DONE;
                default: ;
            endcase
            if (eng_status_we) status_q <= eng_status;
            if (eng_fault) begin
                status_q <= K_FAULT;
                error_q  <= eng_fault_code;
            end
            if (ctl_we) nien_q <= wdata[NIEN_BIT];
            pkt_q   <= (dec_w == DEC_PACKET);
            rdata_q <= rd_en ? rd_mux : '0;
        end
    end

    assign rdata     = rdata_q;
    assign pkt_start = pkt_q;
    assign intrq     = pend_w && !nien_q;

endmodule

// File: rtl/pktdev_taskfile_chk.sv
module pktdev_taskfile_chk
    import pktdev_tf_pkg::*;
#(
    parameter int DW = TF_DW,
    parameter int AW = TF_AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          eng_status_we,
    input logic          eng_fault,
    input logic [DW-1:0] eng_fault_code,
    input logic [DW-1:0] status,
    input logic [DW-1:0] error_r,
    input logic [DW-1:0] cnt,
    input logic          pend,
    input logic          fsm_idle,
    input logic          irq_raise,
    input logic          intrq,
    input logic          pkt_start
);
    localparam logic [DW-1:0] C_BLOCK = DW'(ST_BLOCK);
    localparam logic [DW-1:0] C_DONE  = DW'(ST_READY | ST_SERV);
    localparam logic [DW-1:0] C_DRQ   = DW'(ST_DRQ);
    localparam logic [DW-1:0] C_FAULT = DW'(ST_FAULT);

    a_r2_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_COUNT) && (status & C_BLOCK) != '0 && fsm_idle)
        |=> $stable(cnt));

    a_r4_alt_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_CTL_ALT) && fsm_idle) |=> (pend == $past(pend)));

    a_r6_done_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsm_idle && !eng_status_we && !eng_fault) |=> ((status & C_DONE) == C_DONE));

    a_r12_fault_load: assert property (@(posedge clk) disable iff (!rst_n)
        eng_fault |=> (status == C_FAULT && error_r == $past(eng_fault_code)));

    a_r11_raise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |-> intrq);

    a_r8_pkt_drq: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !$past(eng_status_we) && !$past(eng_fault)) |-> ((status & C_DRQ) != '0));

endmodule

bind pktdev_taskfile pktdev_taskfile_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr           (addr),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .eng_status_we  (eng_status_we),
    .eng_fault      (eng_fault),
    .eng_fault_code (eng_fault_code),
    .status         (status_q),
    .error_r        (error_q),
    .cnt            (count_q),
    .pend           (pend_w),
    .fsm_idle       (fsm_idle),
    .irq_raise      (irq_raise),
    .intrq          (intrq),
    .pkt_start      (pkt_start)
);

// File: tb/pktdev_taskfile_bench.sv
module pktdev_taskfile_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       eng_status_we = 1'b0, eng_fault = 1'b0;
    logic [7:0] eng_status = '0, eng_fault_code = '0;
    logic       irq_raise, irq_clear, intrq, pkt_start;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    pktdev_taskfile u_pktdev_taskfile (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .eng_status_we(eng_status_we),
        .eng_status(eng_status), .eng_fault(eng_fault), .eng_fault_code(eng_fault_code),
        .irq_raise(irq_raise), .irq_clear(irq_clear), .intrq(intrq), .pkt_start(pkt_start)
    );

    // behavioural reference model
    logic [7:0] m_feat, m_cnt, m_lo, m_mid, m_hi, m_dev, m_stat, m_err, m_cmd;
    bit         m_dis, m_pend, m_dec;
    logic [7:0] e_rd;
    bit         e_r, e_c, e_pk;

    always @(posedge clk) begin : model
        logic [7:0] rv, nstat;
        bit clr, set, p, r, c, ok, nd, pk;
        if (!rst_n) begin
            m_err = 8'h01; m_cnt = 8'h01; m_lo = 8'h81; m_mid = 8'h14; m_hi = 8'hEB;
            m_feat = 0; m_dev = 0; m_stat = 0; m_cmd = 0;
            m_dis = 0; m_pend = 0; m_dec = 0;
            e_rd = 0; e_r = 0; e_c = 0; e_pk = 0;
        end else begin
            rv = 0;
            if (rd_en) begin
                case (addr)
                    1: rv = m_err;  2: rv = m_cnt; 3: rv = m_lo; 4: rv = m_mid;
                    5: rv = m_hi;   6: rv = m_dev; 7: rv = m_stat; 8: rv = m_stat;
                    default: rv = 0;
                endcase
            end
            clr = 0; set = 0; pk = 0; nd = 0;
            nstat = m_stat;
            ok = ((m_stat & 8'h88) == 0) && !m_dec;
            if (rd_en && addr == 7 && !m_stat[7]) clr = 1;
            if (m_dec) begin
                if (m_cmd == 8'h08) begin
                    m_err = 8'h01; m_cnt = 8'h01; m_lo = 8'h81; m_mid = 8'h14; m_hi = 8'hEB;
                    m_feat = 0; m_dev = 0; nstat = 8'h50;
                end else if (m_cmd == 8'hA0) begin
                    nstat = m_stat | 8'h58; pk = 1;
                end else begin
                    nstat = m_stat | 8'h50;
                    if (m_cmd == 8'hEF) set = 1;
                end
            end
            if (wr_en && ok) begin
                case (addr)
                    1: m_feat = wdata; 2: m_cnt = wdata; 3: m_lo = wdata;
                    4: m_mid = wdata;  5: m_hi = wdata;  6: m_dev = wdata;
                    7: begin clr = 1; m_cmd = wdata; nd = 1; end
                    default: ;
                endcase
            end
            if (eng_status_we) nstat = eng_status;
            if (eng_fault) begin nstat = 8'h51; m_err = eng_fault_code; end
            p = m_pend; r = 0; c = 0;
            if (clr && p) begin p = 0; c = !m_dis; end
            if (set && !p) begin p = 1; r = !m_dis; end
            if (wr_en && addr == 8) begin
                if (p && !m_dis && wdata[1]) c = 1;
                if (p && m_dis && !wdata[1]) r = 1;
                m_dis = wdata[1];
            end
            m_pend = p; m_stat = nstat; m_dec = nd;
            e_rd = rv; e_r = r; e_c = c; e_pk = pk;
        end
    end

    task automatic tick();
        bit e_int;
        @(negedge clk);
        e_int = m_pend && !m_dis;
        checks++;
        if (rdata !== e_rd || irq_raise !== e_r || irq_clear !== e_c ||
            intrq !== e_int || pkt_start !== e_pk) begin
            errors++;
            $display("FAIL %s: rdata=%h exp %h raise=%b exp %b clear=%b exp %b intrq=%b exp %b pkt=%b exp %b",
                     tag, rdata, e_rd, irq_raise, e_r, irq_clear, e_c, intrq, e_int, pkt_start, e_pk);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic hrd(input logic [3:0] a, input logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: read addr %0d got %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_int(input bit exp);
        checks++;
        if (intrq !== exp) begin
            errors++;
            $display("FAIL %s: intrq got %b expected %b", tag, intrq, exp);
        end
    endtask

    task automatic eng_st(input logic [7:0] v);
        eng_status = v; eng_status_we = 1'b1;
        tick();
        eng_status_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        tag = "R1"; repeat (3) tick();
        rst_n = 1'b1;
        hrd(2, 8'h01); hrd(1, 8'h01); hrd(3, 8'h81); hrd(4, 8'h14);
        hrd(5, 8'hEB); hrd(6, 8'h00); chk_int(0);
        tag = "R3"; hrd(7, 8'h00); hrd(8, 8'h00); hrd(9, 8'h00); tick();

        tag = "R2";
        hwr(1, 8'h11); hwr(2, 8'h22); hwr(3, 8'h33); hwr(6, 8'hA5);
        hrd(2, 8'h22); hrd(3, 8'h33); hrd(6, 8'hA5);
        eng_st(8'h08); hwr(2, 8'h99); hrd(2, 8'h22);
        eng_st(8'h80); hwr(3, 8'h77); hrd(3, 8'h33);
        hwr(7, 8'hEF); tick(); tick(); chk_int(0); hrd(7, 8'h80);
        eng_st(8'h00);

        tag = "R7"; hwr(7, 8'hEF); tick(); tick(); chk_int(1); hrd(7, 8'h50);
        hwr(7, 8'hEF); tick(); tick(); chk_int(1);
        tag = "R4"; hrd(8, 8'h50); chk_int(1);

        tag = "R5"; eng_st(8'h80); hrd(7, 8'h80); chk_int(1);
        eng_st(8'h50); hrd(7, 8'h50); chk_int(0); tick();

        tag = "R10"; hwr(7, 8'hEF); tick(); tick(); chk_int(1);
        hwr(8, 8'h02); chk_int(0); hwr(8, 8'h00); chk_int(1);
        hwr(8, 8'h02); hrd(7, 8'h50); hwr(8, 8'h00); chk_int(0); tick();

        tag = "R11"; hwr(8, 8'h02); hwr(7, 8'hEF); tick(); tick(); chk_int(0);
        hwr(8, 8'h00); chk_int(1);
        hwr(7, 8'hEF); tick(); tick(); chk_int(1);
        tag = "R13"; hwr(8, 8'h02); chk_int(0); hwr(8, 8'h00); chk_int(1);

        tag = "R8"; eng_st(8'h00); hwr(7, 8'hA0); tick(); tick();
        hrd(7, 8'h58); hwr(2, 8'h55); hrd(2, 8'h22);

        tag = "R12"; eng_fault_code = 8'h50; eng_fault = 1'b1; tick(); eng_fault = 1'b0;
        hrd(7, 8'h51); hrd(1, 8'h50);

        tag = "R9"; eng_st(8'h00); hwr(2, 8'h66); hwr(7, 8'h08); tick(); tick();
        hrd(2, 8'h01); hrd(3, 8'h81); hrd(1, 8'h01); hrd(6, 8'h00); hrd(7, 8'h50);

        tag = "R6"; eng_st(8'h00); hwr(7, 8'h20); tick(); tick(); hrd(7, 8'h50);
        tick(); tick();
        finish_run();
    end

endmodule